// File: doc/BRIEF.md
# Sticky Error Status Register

This block collects error and warning events from a position-sensing system and shows them as three read-only status bytes at consecutive addresses. Every event pulse sets a matching flag. The flag stays set until software reads the byte that holds it, or until a soft-reset command arrives. The encoding is active-high, so a 1 means the condition is present.

Two bits follow special rules. The configuration-error flag, which reports a missing setup memory or a setup checksum failure at startup, survives a soft reset. The top bit of the last byte is not stored at all. It reflects, live, whether a command is running on the internal converter or the internal data bus, or whether the system is still starting up.

A read strobe with an address returns that byte one cycle later. The returned value is the content before any clearing. Only the flags of the addressed byte are cleared, and an address outside the window returns zero and changes nothing.

Top module: `sticky_status_reg`

## Requirements
- R1: Event input `evt_set[8*k+b]` maps to bit `b` of the byte at address 0x75+k, for k = 0, 1, 2. Bit 6 of 0x75 is the configuration-error flag and bit 7 of 0x77 is the live busy bit. A bit reads 1 when its condition is true.
- R2: A one-cycle high pulse on an event input sets its flag at the next clock edge. The flag then holds with no further event.
- R3: A read strobe at a valid address presents that byte on `rd_data` on the cycle after the strobe, with the content from before the clearing. The same edge clears the latched flags of that byte only. The other bytes are untouched.
- R4: A soft-reset pulse clears every latched flag at the next edge, except bit 6 of 0x75.
- R5: Bit 6 of 0x75 keeps its value through a soft reset. It is cleared only by a read of 0x75 or by the hardware reset.
- R6: Bit 7 of 0x77 reads as the OR of `busy_conv`, `busy_bus` and `startup` in the strobe cycle. It is never latched, and `evt_set[23]` has no effect.
- R7: When an event and a clear, whether from a read or a soft reset, hit the same flag in the same cycle, the flag ends up set.
- R8: A strobe at an address outside 0x75 to 0x77 returns zero and clears no flag.
- R9: After the hardware reset, all flags are zero and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| evt_set | input | 24 | Per-flag event pulses, with bit 8*k+b going to byte 0x75+k, bit b |
| busy_conv | input | 1 | A command on the internal converter is running |
| busy_bus | input | 1 | A command on the internal data bus is running |
| startup | input | 1 | The system is in its startup phase |
| soft_rst | input | 1 | Soft-reset command pulse |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 8 | Read data, valid from the cycle after the strobe until the next strobe |

## Verification
There are three kinds of result, and each has its own timing:
- An event, a clear or a soft reset changes the flags at the edge that samples it, so a read issued in the following cycle sees the new value.
- Read data appears one edge after the strobe.
- The live busy bit is captured at that same edge.

The bench drives every input just after a falling edge and samples one full cycle later, after the rising edge that registers the result. Same-cycle collisions are built by driving the event together with the strobe or the soft reset in a single cycle.

// File: rtl/sticky_status_reg.sv
module sticky_status_reg #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h75,
  parameter int NBYTES = 3,
  parameter int CFG_BIT = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [8*NBYTES-1:0] evt_set,
  input  logic                busy_conv,
  input  logic                busy_bus,
  input  logic                startup,
  input  logic                soft_rst,
  input  logic                rd_stb,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [7:0]          rd_data
);
  localparam int NB = 8*NBYTES;
  localparam int LIVE_BIT = NB-1;
  localparam logic [ADDR_W-1:0] NB_A = ADDR_W'(NBYTES);
  localparam logic [NB-1:0] LIVE_M = NB'(1) << LIVE_BIT;
  localparam logic [NB-1:0] CFG_M = NB'(1) << CFG_BIT;

  logic [NB-1:0] stat_q, rd_clr, soft_clr, view;
  logic [ADDR_W-1:0] ofs;
  logic hit, live;
  logic [7:0] sel;

  assign ofs = rd_addr - BASE_ADDR;
  assign hit = rd_stb && (ofs < NB_A);
  assign live = busy_conv | busy_bus | startup;
  assign view = (stat_q & ~LIVE_M) | (live ? LIVE_M : '0);
  assign soft_clr = soft_rst ? ~CFG_M : '0;

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    assign rd_clr[8*k +: 8] = {8{hit && (ofs == ADDR_W'(k))}};
  end

  always_comb begin
    sel = '0;
    for (int k = 0; k < NBYTES; k++)
      if (ofs == ADDR_W'(k)) sel = view[8*k +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      rd_data <= '0;
    end else begin
      stat_q <= (evt_set & ~LIVE_M) | (stat_q & ~rd_clr & ~soft_clr & ~LIVE_M);
      if (rd_stb) rd_data <= hit ? sel : 8'h00;
    end
  end
endmodule

module sticky_status_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h75,
  parameter int NBYTES = 3,
  parameter int CFG_BIT = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic [8*NBYTES-1:0] evt_set,
  input logic                busy_conv,
  input logic                busy_bus,
  input logic                startup,
  input logic                soft_rst,
  input logic                rd_stb,
  input logic [ADDR_W-1:0]   rd_addr,
  input logic [7:0]          rd_data,
  input logic [8*NBYTES-1:0] stat_q
);
  localparam int NB = 8*NBYTES;
  localparam logic [NB-1:0] SET_M = ~(NB'(1) << (NB-1));
  localparam logic [NB-1:0] CFG_M = NB'(1) << CFG_BIT;
  localparam logic [ADDR_W-1:0] LAST_A = BASE_ADDR + ADDR_W'(NBYTES-1);

  logic oor;
  assign oor = (rd_addr < BASE_ADDR) || (rd_addr > LAST_A);

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_set & SET_M)) |=> ((stat_q & $past(evt_set & SET_M)) == $past(evt_set & SET_M))); // R7
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !soft_rst && !(|evt_set)) |=> $stable(stat_q)); // R2
  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !(|evt_set)) |=> ((stat_q & ~CFG_M) == '0)); // R4
  AST_CFG_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && stat_q[CFG_BIT] && !(rd_stb && rd_addr == BASE_ADDR)) |=> stat_q[CFG_BIT]); // R5
  AST_LIVE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_addr == LAST_A) |=> (rd_data[7] == $past(busy_conv | busy_bus | startup))); // R6
  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && oor) |=> (rd_data == 8'h00)); // R8
  AST_OOR_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && oor && !soft_rst) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R8
endmodule

bind sticky_status_reg sticky_status_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NBYTES(NBYTES), .CFG_BIT(CFG_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .busy_conv(busy_conv),
  .busy_bus(busy_bus), .startup(startup), .soft_rst(soft_rst),
  .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data), .stat_q(stat_q)
);

// File: tb/sticky_status_reg_tb.sv
module sticky_status_reg_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [23:0] evt_set = '0;
  logic busy_conv = 1'b0, busy_bus = 1'b0, startup = 1'b0;
  logic soft_rst = 1'b0, rd_stb = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sticky_status_reg u_dut (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .busy_conv(busy_conv),
    .busy_bus(busy_bus), .startup(startup), .soft_rst(soft_rst),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic pulse_evt(logic [23:0] v);
    @(negedge clk); evt_set = v;
    @(negedge clk); evt_set = '0;
  endtask

  task automatic rd(logic [7:0] a, string req, logic [7:0] exp);
    @(negedge clk); rd_stb = 1'b1; rd_addr = a;
    @(negedge clk); rd_stb = 1'b0;
    check(req, rd_data, exp);
  endtask

  task automatic t_reset;
    check("R9 rd_data after reset", rd_data, 8'h00);
    rd(8'h75, "R9 byte0", 8'h00);
    rd(8'h76, "R9 byte1", 8'h00);
    rd(8'h77, "R9 byte2", 8'h00);
  endtask

  task automatic t_map;
    pulse_evt(24'h000001);
    repeat (3) @(negedge clk);
    rd(8'h75, "R1 R2 bit0 of 0x75", 8'h01);
    pulse_evt(24'h002000);
    rd(8'h76, "R1 bit5 of 0x76", 8'h20);
    pulse_evt(24'h020000);
    rd(8'h77, "R1 bit1 of 0x77", 8'h02);
  endtask

  task automatic t_clear_read;
    pulse_evt(24'h000404);
    rd(8'h75, "R3 pre-clear value", 8'h04);
    rd(8'h75, "R3 cleared after read", 8'h00);
    rd(8'h76, "R3 other byte kept", 8'h04);
  endtask

  task automatic t_soft;
    pulse_evt(24'h100060);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    rd(8'h75, "R4 R5 only cfg flag left", 8'h40);
    rd(8'h77, "R4 byte2 cleared", 8'h00);
    rd(8'h75, "R5 cfg cleared by read", 8'h00);
  endtask

  task automatic t_live;
    busy_conv = 1'b1;
    rd(8'h77, "R6 converter busy", 8'h80);
    busy_conv = 1'b0; busy_bus = 1'b1;
    rd(8'h77, "R6 bus busy", 8'h80);
    busy_bus = 1'b0; startup = 1'b1;
    rd(8'h77, "R6 startup", 8'h80);
    startup = 1'b0;
    rd(8'h77, "R6 idle", 8'h00);
    pulse_evt(24'h800000);
    rd(8'h77, "R6 event on live bit ignored", 8'h00);
  endtask

  task automatic t_collide;
    pulse_evt(24'h000008);
    @(negedge clk); rd_stb = 1'b1; rd_addr = 8'h75; evt_set = 24'h000008;
    @(negedge clk); rd_stb = 1'b0; evt_set = '0;
    check("R7 read value in collision", rd_data, 8'h08);
    rd(8'h75, "R7 flag survives read clear", 8'h08);
    @(negedge clk); soft_rst = 1'b1; evt_set = 24'h000200;
    @(negedge clk); soft_rst = 1'b0; evt_set = '0;
    rd(8'h76, "R7 flag survives soft reset", 8'h02);
  endtask

  task automatic t_oor;
    pulse_evt(24'h000002);
    rd(8'h74, "R8 below window", 8'h00);
    rd(8'h78, "R8 above window", 8'h00);
    rd(8'h00, "R8 address zero", 8'h00);
    rd(8'h75, "R8 flag not cleared", 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_clear_read();
    t_soft();
    t_live();
    t_collide();
    t_oor();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule